// File: doc/BRIEF.md
# Security-Filtered Interrupt State Bitmaps

This block keeps four bits of state for every shared interrupt (enable, pending, active and group) together with the sampled input level and an edge/level trigger choice. Software reaches the state one 32-bit word at a time. It names a view with a register select and a word with a word index. Each state has a view that sets bits and a view that clears bits, and both views read back the same stored state.

Every access carries a secure attribute. When the chip runs with two security states (`sec_off` low), a non-secure access only reaches the bits of interrupts whose group bit is 1. A 2-bit per-interrupt permission code can extend this reach for some views. Secure accesses, and all accesses while `sec_off` is high, see every bit.

The interrupt lines are sampled every clock. A 0→1 change on a line latches pending when that interrupt is edge-triggered. For level-triggered interrupts, the pending value read back includes the live level.

Top module: `irq_bitmap_regs`

## Requirements
- R1: After a synchronous active-low reset, every state bit, every permission code and `rd_data` are zero, and every interrupt is level-triggered.
- R2: The set views use select 1 (enable), 3 (pending) and 5 (active). Writing 1 to a permitted bit sets it. Writing 0 leaves it unchanged.
- R3: The clear views use select 2 (enable), 4 (pending) and 6 (active). Writing 1 to a permitted bit clears it. Writing 0 leaves it unchanged. Reading a clear view returns the same masked state as reading its set view.
- R4: For a non-secure access with `sec_off` low, bits whose group bit is 0, and that the permission code does not open, read as zero and ignore writes. A secure access, or any access with `sec_off` high, reaches all bits.
- R5: Permission codes are written through select 8 and select 9. In word w, select 8 holds interrupts 32w+0..15 and select 9 holds interrupts 32w+16..31. Interrupt 32w+k uses bits [2k+1:2k] of its half, taken modulo 16. A code of at least 1 opens the pending-set view. A code of at least 2 opens the pending-clear view and the reading of both active views. Enable views and active writes are opened by the group bit alone.
- R6: A pending read returns the latch OR (sampled level AND NOT edge-triggered).
- R7: A line that rises on an edge-triggered interrupt sets its pending latch. A rise on a level-triggered interrupt does not set the latch, and neither does a steady level.
- R8: Word 0 (interrupts 0..31) and words at or above NUM_IRQ/32 read as zero and ignore writes.
- R9: The group view (select 0) is reachable only by secure accesses or while `sec_off` is high; otherwise it reads zero and ignores writes. The permission-code views are reachable only by secure accesses while `sec_off` is low; otherwise they read zero and ignore writes.
- R10: The trigger view (select 7) stores 1 for edge-triggered and 0 for level-triggered. Its reads and writes use the group-only mask of R4.
- R11: When a line rises on an edge-triggered interrupt in the same cycle that a pending-clear write targets that interrupt, the pending latch ends set.
- R12: `rd_data` is loaded on the clock edge where `rd` is high and holds its value while `rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 4 | View select (0 group, 1..6 set/clear views, 7 trigger, 8/9 permission codes) |
| idx | input | IDX_W | Word index; word w covers interrupts 32w..32w+31 |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| secure | input | 1 | Secure attribute of the access |
| sec_off | input | 1 | Single security state: when high, all accesses are treated as fully permitted |
| wdata | input | 32 | Write data |
| irq_spi | input | NUM_IRQ-32 | Interrupt lines; bit j belongs to interrupt 32+j |
| rd_data | output | 32 | Read data, registered |

## Verification
The bench builds the block with NUM_IRQ = 96, so two shared words (1 and 2) exist. With this value, word 0 and word 3 reach the zero-read, write-ignored edges on both sides of the implemented range. Word 1 carries the group-mask and trigger scenarios, and word 2, which stays in group 0, isolates the permission-code thresholds. Both halves of the permission code storage are reached, including an interrupt in the upper half.

// File: rtl/irq_bitmap_pkg.sv
// Package: shared view encoding and per-view permission thresholds.
// Assumes a 4-bit view select; threshold 0 means "group bit only".
package irq_bitmap_pkg;

    typedef enum logic [3:0] {
        V_GROUP    = 4'd0,
        V_EN_SET   = 4'd1,
        V_EN_CLR   = 4'd2,
        V_PEND_SET = 4'd3,
        V_PEND_CLR = 4'd4,
        V_ACT_SET  = 4'd5,
        V_ACT_CLR  = 4'd6,
        V_EDGE     = 4'd7,
        V_CODE_LO  = 4'd8,
        V_CODE_HI  = 4'd9
    } view_e;

    // Minimum permission code that opens a view for reading (0: none)
    function automatic logic [1:0] read_thr(view_e v);
        case (v)
            V_PEND_SET:          return 2'd1;
            V_PEND_CLR:          return 2'd2;
            V_ACT_SET, V_ACT_CLR: return 2'd2;
            default:             return 2'd0;
        endcase
    endfunction

    // Minimum permission code that opens a view for writing (0: none)
    function automatic logic [1:0] write_thr(view_e v);
        case (v)
            V_PEND_SET: return 2'd1;
            V_PEND_CLR: return 2'd2;
            default:    return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/irq_access_gate.sv
// Access gate: builds the per-bit permission mask for one 32-interrupt word.
// Assumes codes holds two bits per interrupt, interrupt k at [2k+1:2k].
// A threshold of zero disables the code extension so only the group counts.
module irq_access_gate #(
    parameter int WORD_BITS = 32
) (
    input  logic [WORD_BITS-1:0]   grp,
    input  logic [2*WORD_BITS-1:0] codes,
    input  logic [1:0]             thr,
    input  logic                   secure,
    input  logic                   sec_off,
    output logic [WORD_BITS-1:0]   mask
);
    logic [WORD_BITS-1:0] ext;

    // One comparator per interrupt: does its code reach the threshold
    for (genvar k = 0; k < WORD_BITS; k++) begin : g_cmp
        assign ext[k] = (thr != 2'd0) && (codes[2*k +: 2] >= thr);
    end

    // Full reach for secure or single-state accesses, filtered otherwise
    assign mask = (secure || sec_off) ? {WORD_BITS{1'b1}} : (grp | ext);

endmodule

// File: rtl/irq_state_word.sv
// State word: holds group/enable/pending/active/trigger/level/code state
// for 32 shared interrupts and serves one view per access.
// Assumes wr is already qualified by the word index; reads are combinational.
module irq_state_word
    import irq_bitmap_pkg::*;
#(
    parameter int WORD_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  view_e                sel,
    input  logic                 wr,
    input  logic [WORD_BITS-1:0] wdata,
    input  logic                 secure,
    input  logic                 sec_off,
    input  logic [WORD_BITS-1:0] line,
    output logic [WORD_BITS-1:0] rdata
);
    localparam int CODE_BITS = 2 * WORD_BITS;
    localparam int HALF      = CODE_BITS / 2;

    logic [WORD_BITS-1:0] grp_q, en_q, pend_q, act_q, edge_q, lvl_q;
    logic [WORD_BITS-1:0] grp_d, en_d, pend_d, act_d, edge_d;
    logic [CODE_BITS-1:0] code_q, code_d;
    logic [WORD_BITS-1:0] rmask, wmask, rise_edge, pend_view;
    logic                 grp_ok, code_ok;

    irq_access_gate #(.WORD_BITS(WORD_BITS)) u_rgate (
        .grp(grp_q), .codes(code_q), .thr(read_thr(sel)),
        .secure(secure), .sec_off(sec_off), .mask(rmask)
    );

    irq_access_gate #(.WORD_BITS(WORD_BITS)) u_wgate (
        .grp(grp_q), .codes(code_q), .thr(write_thr(sel)),
        .secure(secure), .sec_off(sec_off), .mask(wmask)
    );

    assign grp_ok    = secure || sec_off;
    assign code_ok   = secure && !sec_off;
    assign rise_edge = line & ~lvl_q & edge_q;
    assign pend_view = pend_q | (lvl_q & ~edge_q);

    // Next-state: apply the software write, then let edge rises win
    always_comb begin
        grp_d  = grp_q;
        en_d   = en_q;
        pend_d = pend_q;
        act_d  = act_q;
        edge_d = edge_q;
        code_d = code_q;
        if (wr) begin
            case (sel)
                V_GROUP:    if (grp_ok) grp_d = wdata;
                V_EN_SET:   en_d   = en_q | (wdata & wmask);
                V_EN_CLR:   en_d   = en_q & ~(wdata & wmask);
                V_PEND_SET: pend_d = pend_q | (wdata & wmask);
                V_PEND_CLR: pend_d = pend_q & ~(wdata & wmask);
                V_ACT_SET:  act_d  = act_q | (wdata & wmask);
                V_ACT_CLR:  act_d  = act_q & ~(wdata & wmask);
                V_EDGE:     edge_d = (edge_q & ~wmask) | (wdata & wmask);
                V_CODE_LO:  if (code_ok) code_d[HALF-1:0] = wdata;
                V_CODE_HI:  if (code_ok) code_d[CODE_BITS-1:HALF] = wdata;
                default:    ;
            endcase
        end
        pend_d = pend_d | rise_edge;
    end

    // State registers with synchronous reset to all-clear, level-triggered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q  <= '0;
            en_q   <= '0;
            pend_q <= '0;
            act_q  <= '0;
            edge_q <= '0;
            lvl_q  <= '0;
            code_q <= '0;
        end else begin
            grp_q  <= grp_d;
            en_q   <= en_d;
            pend_q <= pend_d;
            act_q  <= act_d;
            edge_q <= edge_d;
            lvl_q  <= line;
            code_q <= code_d;
        end
    end

    // Read view: masked state of the selected view
    always_comb begin
        case (sel)
            V_GROUP:              rdata = grp_ok ? grp_q : '0;
            V_EN_SET, V_EN_CLR:   rdata = en_q & rmask;
            V_PEND_SET, V_PEND_CLR: rdata = pend_view & rmask;
            V_ACT_SET, V_ACT_CLR: rdata = act_q & rmask;
            V_EDGE:               rdata = edge_q & rmask;
            V_CODE_LO:            rdata = code_ok ? code_q[HALF-1:0] : '0;
            V_CODE_HI:            rdata = code_ok ? code_q[CODE_BITS-1:HALF] : '0;
            default:              rdata = '0;
        endcase
    end

    // An edge rise on an edge-triggered line must leave pending set (R7, R11)
    assert_edge_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_edge != '0) |=> ((pend_q & $past(rise_edge)) == $past(rise_edge)));

    // Pending only rises through a pending-set write or an edge rise (R7)
    assert_no_level_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && sel == V_PEND_SET) |=>
        ((pend_q & ~$past(pend_q) & ~$past(rise_edge)) == '0));

    // Non-secure group writes in two-state mode leave the group intact (R9)
    assert_group_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !secure && !sec_off && sel == V_GROUP) |=> $stable(grp_q));

    // Enable bits outside the write mask never change on an enable write (R4)
    assert_enable_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (sel == V_EN_SET || sel == V_EN_CLR)) |=>
        (((en_q ^ $past(en_q)) & ~$past(wmask)) == '0));

endmodule

// File: rtl/irq_bitmap_regs.sv
// Top: word-addressed, security-filtered interrupt state bitmaps.
// Assumes NUM_IRQ is a multiple of 32 and at least 64; word 0 holds the
// internal IDs and has no storage. One access per clock; reads registered.
module irq_bitmap_regs
    import irq_bitmap_pkg::*;
#(
    parameter int NUM_IRQ = 128,
    parameter int IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         sel,
    input  logic [IDX_W-1:0]   idx,
    input  logic               rd,
    input  logic               wr,
    input  logic               secure,
    input  logic               sec_off,
    input  logic [31:0]        wdata,
    input  logic [NUM_IRQ-33:0] irq_spi,
    output logic [31:0]        rd_data
);
    localparam int WORD_BITS = 32;
    localparam int NWORDS    = NUM_IRQ / WORD_BITS;

    view_e                view;
    logic [WORD_BITS-1:0] word_rd [NWORDS];
    logic [WORD_BITS-1:0] rd_val;
    logic                 idx_live;

    assign view       = view_e'(sel);
    assign word_rd[0] = '0;
    assign idx_live   = (idx != '0) && (int'(idx) < NWORDS);

    // One state word per implemented shared word
    for (genvar w = 1; w < NWORDS; w++) begin : g_word
        irq_state_word #(.WORD_BITS(WORD_BITS)) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (view),
            .wr      (wr && (int'(idx) == w)),
            .wdata   (wdata),
            .secure  (secure),
            .sec_off (sec_off),
            .line    (irq_spi[(w-1)*WORD_BITS +: WORD_BITS]),
            .rdata   (word_rd[w])
        );
    end

    // Read mux: zero for internal and unimplemented words
    assign rd_val = idx_live ? word_rd[idx] : '0;

    // Read data register, loaded only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)  rd_data <= '0;
        else if (rd) rd_data <= rd_val;
    end

    // Reads outside the implemented range return zero (R8)
    assert_range_raz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !idx_live) |=> (rd_data == '0));

    // Read data holds between read strobes (R12)
    assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rd_data));

endmodule

// File: tb/sim_irq_bitmap_regs.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_irq_bitmap_regs;
    localparam int NUM_IRQ = 96;
    localparam int IDX_W   = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [3:0]         sel = '0;
    logic [IDX_W-1:0]   idx = '0;
    logic               rd = 1'b0;
    logic               wr = 1'b0;
    logic               secure = 1'b1;
    logic               sec_off = 1'b0;
    logic [31:0]        wdata = '0;
    logic [NUM_IRQ-33:0] irq_spi = '0;
    logic [31:0]        rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    irq_bitmap_regs #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .idx(idx), .rd(rd), .wr(wr),
        .secure(secure), .sec_off(sec_off), .wdata(wdata),
        .irq_spi(irq_spi), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr_op(input logic [3:0] v, input int i, input logic [31:0] d, input logic s);
        sel = v; idx = IDX_W'(i); wdata = d; secure = s; wr = 1'b1;
        cyc();
        wr = 1'b0;
    endtask

    task automatic rd_op(input logic [3:0] v, input int i, input logic s, output logic [31:0] val);
        sel = v; idx = IDX_W'(i); secure = s; rd = 1'b1;
        cyc();
        rd = 1'b0;
        val = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 rd_data", rd_data, 32'h0);
        rd_op(4'd1, 1, 1'b1, v); check("R1 enable", v, 32'h0);
        rd_op(4'd3, 2, 1'b1, v); check("R1 pending", v, 32'h0);
        rd_op(4'd7, 1, 1'b1, v); check("R1 trigger level", v, 32'h0);
        rd_op(4'd8, 2, 1'b1, v); check("R1 codes", v, 32'h0);
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        wr_op(4'd1, 1, 32'h0000_00F0, 1'b1);
        rd_op(4'd1, 1, 1'b1, v); check("R2 set", v, 32'h0000_00F0);
        wr_op(4'd1, 1, 32'h0000_0001, 1'b1);
        rd_op(4'd1, 1, 1'b1, v); check("R2 zero ignored", v, 32'h0000_00F1);
        wr_op(4'd2, 1, 32'h0000_0030, 1'b1);
        rd_op(4'd1, 1, 1'b1, v); check("R3 clear", v, 32'h0000_00C1);
        rd_op(4'd2, 1, 1'b1, v); check("R3 clear view read", v, 32'h0000_00C1);
        wr_op(4'd2, 1, 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_ns_mask();
        logic [31:0] v;
        wr_op(4'd0, 1, 32'h0000_FFFF, 1'b1);
        wr_op(4'd1, 1, 32'hFFFF_FFFF, 1'b0);
        rd_op(4'd1, 1, 1'b1, v); check("R4 ns set masked", v, 32'h0000_FFFF);
        wr_op(4'd1, 1, 32'hFFFF_0000, 1'b1);
        rd_op(4'd1, 1, 1'b0, v); check("R4 ns read masked", v, 32'h0000_FFFF);
        wr_op(4'd2, 1, 32'hFFFF_FFFF, 1'b0);
        rd_op(4'd1, 1, 1'b1, v); check("R4 ns clear masked", v, 32'hFFFF_0000);
        rd_op(4'd0, 1, 1'b0, v); check("R9 ns group raz", v, 32'h0);
        wr_op(4'd0, 1, 32'h0, 1'b0);
        rd_op(4'd0, 1, 1'b1, v); check("R9 ns group wi", v, 32'h0000_FFFF);
        sec_off = 1'b1;
        wr_op(4'd1, 1, 32'hFFFF_FFFF, 1'b0);
        rd_op(4'd1, 1, 1'b0, v); check("R4 single state full", v, 32'hFFFF_FFFF);
        rd_op(4'd0, 1, 1'b0, v); check("R9 single state group", v, 32'h0000_FFFF);
        wr_op(4'd8, 1, 32'hFFFF_FFFF, 1'b1);
        rd_op(4'd8, 1, 1'b1, v); check("R9 codes raz single state", v, 32'h0);
        sec_off = 1'b0;
        rd_op(4'd8, 1, 1'b1, v); check("R9 codes wi single state", v, 32'h0);
    endtask

    task automatic t_codes();
        logic [31:0] v;
        wr_op(4'd8, 2, 32'h0000_0039, 1'b1);
        rd_op(4'd8, 2, 1'b0, v); check("R9 ns codes raz", v, 32'h0);
        rd_op(4'd8, 2, 1'b1, v); check("R5 codes readback", v, 32'h0000_0039);
        wr_op(4'd3, 2, 32'h0000_000F, 1'b0);
        rd_op(4'd3, 2, 1'b1, v); check("R5 pend set thr1", v, 32'h0000_0007);
        rd_op(4'd3, 2, 1'b0, v); check("R5 ns pend read thr1", v, 32'h0000_0007);
        wr_op(4'd4, 2, 32'h0000_000F, 1'b0);
        rd_op(4'd3, 2, 1'b1, v); check("R5 pend clear thr2", v, 32'h0000_0001);
        rd_op(4'd4, 2, 1'b0, v); check("R5 ns pend clear view", v, 32'h0);
        wr_op(4'd5, 2, 32'h0000_000F, 1'b1);
        rd_op(4'd5, 2, 1'b0, v); check("R5 ns active read thr2", v, 32'h0000_0006);
        wr_op(4'd6, 2, 32'h0000_000F, 1'b0);
        rd_op(4'd6, 2, 1'b1, v); check("R5 active write group only", v, 32'h0000_000F);
        wr_op(4'd9, 2, 32'h0000_0001, 1'b1);
        wr_op(4'd3, 2, 32'h0001_0000, 1'b0);
        rd_op(4'd3, 2, 1'b1, v); check("R5 upper half code", v, 32'h0001_0001);
    endtask

    task automatic t_level_edge();
        logic [31:0] v;
        irq_spi[8] = 1'b1; cyc();
        rd_op(4'd3, 1, 1'b1, v); check("R6 level merged", v, 32'h0000_0100);
        irq_spi[8] = 1'b0; cyc();
        rd_op(4'd3, 1, 1'b1, v); check("R7 level no latch", v, 32'h0);
        wr_op(4'd7, 1, 32'h0000_0100, 1'b1);
        rd_op(4'd7, 1, 1'b1, v); check("R10 trigger readback", v, 32'h0000_0100);
        irq_spi[8] = 1'b1; cyc();
        irq_spi[8] = 1'b0; cyc();
        rd_op(4'd3, 1, 1'b1, v); check("R7 edge latched", v, 32'h0000_0100);
        irq_spi[8] = 1'b1; cyc();
        wr_op(4'd4, 1, 32'h0000_0100, 1'b1);
        rd_op(4'd3, 1, 1'b1, v); check("R7 steady no relatch", v, 32'h0);
        irq_spi[8] = 1'b0; cyc();
        irq_spi[8] = 1'b1;
        wr_op(4'd4, 1, 32'h0000_0100, 1'b1);
        rd_op(4'd3, 1, 1'b1, v); check("R11 edge beats clear", v, 32'h0000_0100);
        irq_spi[8] = 1'b0;
        wr_op(4'd7, 1, 32'hFFFF_FFFF, 1'b0);
        rd_op(4'd7, 1, 1'b1, v); check("R10 ns trigger masked", v, 32'h0000_FFFF);
        rd_op(4'd7, 1, 1'b0, v); check("R10 ns trigger read", v, 32'h0000_FFFF);
    endtask

    task automatic t_range();
        logic [31:0] v;
        irq_spi = '0;
        wr_op(4'd1, 0, 32'hFFFF_FFFF, 1'b1);
        rd_op(4'd1, 0, 1'b1, v); check("R8 word0 raz", v, 32'h0);
        wr_op(4'd1, 3, 32'hFFFF_FFFF, 1'b1);
        rd_op(4'd1, 3, 1'b1, v); check("R8 beyond range raz", v, 32'h0);
        rd_op(4'd1, 2, 1'b1, v); check("R8 word2 untouched", v, 32'h0);
        rd_op(4'd1, 1, 1'b1, v); check("R12 loaded", v, 32'hFFFF_FFFF);
        wr_op(4'd2, 1, 32'hFFFF_FFFF, 1'b1);
        check("R12 held", rd_data, 32'hFFFF_FFFF);
    endtask

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_set_clear();
        t_ns_mask();
        t_codes();
        t_level_edge();
        t_range();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule